// File: doc/BRIEF.md
# Two-Level Bus Arbiter with Parking and Wait Monitor

This block is the central arbiter for a shared parallel bus with up to eight requesters. Requester 0 is the internal agent. Requesters 1 to 7 are external masters. Every requester has an active-low request input and an active-low grant output. A configuration bit for each requester places it in a high or a low priority group. Within a group, requesters are served in rotating order. The arbiter watches the bus idle signals (`frame_n`, `irdy_n`). It moves the grant only while the bus is free, or in the first cycle of a new transaction.

When nobody requests the bus, the grant is parked. Depending on a mode bit, it stays on the current owner or goes to a programmed requester. Requesters 5 to 7 can be switched out, and a switched-out requester can never own the bus. An optional monitor watches the owner of the grant. If the owner keeps requesting but does not start a transaction within 16 idle clocks, the monitor raises a sticky flag and takes the grant away.

Top module: `pci_park_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `gnt_n` is 8'hFE (grant on the internal agent, index 0) and `timeout_flag` is 0.
- R2: Exactly one bit of `gnt_n` is low in every cycle.
- R3: The grant is registered. It can change only after a clock edge at which the bus was free (`frame_n` and `irdy_n` both 1), or at which `frame_n` was 0 after being 1 in the cycle before. The one exception is an owner that becomes switched out (see R8).
- R4: Bit i of `prio_hi` puts requester i (bit 0 = internal agent) in the high group when 1 and in the low group when 0. Any eligible high-group request beats all low-group requests.
- R5: Within a group, the search starts at the index after that group's pointer and wraps from 7 to 0. Both pointers are 7 after reset. A group's pointer takes the owner's index when the owner starts a transaction or times out.
- R6: With `park_fixed` = 0 and no eligible request, the grant stays on its current owner.
- R7: With `park_fixed` = 1 and no eligible request, the grant goes to the requester whose index equals `park_sel` (000 = internal agent, 001 = master 1, up to 111 = master 7).
- R8: Bit j of `opt_en` enables requester 5+j. A disabled requester is never granted. A disabled park target is replaced by the internal agent. If the owner becomes disabled, the grant moves to the internal agent at the next edge.
- R9: With `mon_en` = 1, the monitor acts when one owner keeps its request low while the bus is free for 16 consecutive edges. `timeout_flag` rises after the 16th edge, and at that edge the offender is left out of the arbitration.
- R10: With `mon_en` = 0, `timeout_flag` never rises.
- R11: If another eligible request is pending at a timeout, the grant leaves the offender at that edge.
- R12: `timeout_flag` stays 1 until `to_clear` is 1 at an edge. A timeout at the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 8 | Active-low requests, bit 0 = internal agent |
| frame_n | input | 1 | Active-low transaction frame |
| irdy_n | input | 1 | Active-low initiator ready |
| prio_hi | input | 8 | Per-requester priority group, 1 = high |
| park_fixed | input | 1 | Park mode: 0 = stay on owner, 1 = programmed target |
| park_sel | input | 3 | Programmed park target index |
| opt_en | input | 3 | Enables for requesters 5, 6, 7 (bit 0 = requester 5) |
| mon_en | input | 1 | Wait monitor enable |
| to_clear | input | 1 | Clears the timeout flag |
| gnt_n | output | 8 | Active-low registered grants |
| timeout_flag | output | 1 | Sticky wait-timeout status |

## Verification
Two pairs of events can fall on the same edge. The first pair is a monitor timeout and a clear pulse. The bench holds `to_clear` high through a whole wait window, so the timeout edge meets the clear. It then expects the flag to be 1 after that edge and 0 one edge later. The second pair is a transaction start and a re-arbitration that moves the group pointer at that edge. The bench judges it against its own model, with directed starts while several requesters in one group are pending and with random bursts of `frame_n`.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic {
    PARK_ON_OWNER  = 1'b0,
    PARK_ON_TARGET = 1'b1
  } park_mode_e;

  typedef enum logic [1:0] {
    WIN_HIGH = 2'd0,
    WIN_LOW  = 2'd1,
    WIN_PARK = 2'd2
  } win_src_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_MASTERS = 8,
  parameter int IDX_W     = $clog2(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] cand,
  input  logic [IDX_W-1:0]     last,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);

  // Returns {found, index} of the first set bit after 'last', wrapping.
  function automatic logic [IDX_W:0] scan_after(input logic [N_MASTERS-1:0] m,
                                                input logic [IDX_W-1:0] from);
    logic [IDX_W:0] res;
    res = '0;
    for (int k = N_MASTERS; k >= 1; k--) begin
      int pos;
      pos = (int'(from) + k) % N_MASTERS;
      if (m[pos]) res = {1'b1, IDX_W'(pos)};
    end
    return res;
  endfunction

  logic [IDX_W:0] hit;

  assign hit   = scan_after(cand, last);
  assign found = hit[IDX_W];
  assign idx   = hit[IDX_W-1:0];

endmodule

// File: rtl/arb_park_sel.sv
module arb_park_sel
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 8,
  parameter int IDX_W     = $clog2(N_MASTERS)
) (
  input  logic                 park_fixed,
  input  logic [IDX_W-1:0]     park_sel,
  input  logic [IDX_W-1:0]     owner,
  input  logic [N_MASTERS-1:0] present,
  output logic [IDX_W-1:0]     target
);

  // A target that is not present falls back to the internal agent.
  function automatic logic [IDX_W-1:0] usable(input logic [IDX_W-1:0] want,
                                             input logic [N_MASTERS-1:0] pres);
    return pres[want] ? want : '0;
  endfunction

  park_mode_e mode;

  assign mode   = park_mode_e'(park_fixed);
  assign target = usable((mode == PARK_ON_TARGET) ? park_sel : owner, present);

endmodule

// File: rtl/arb_wait_mon.sv
module arb_wait_mon #(
  parameter int WAIT_LIMIT = 16,
  parameter int CNT_W      = $clog2(WAIT_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic bus_idle,
  input  logic owner_req,
  input  logic grant_moves,
  input  logic to_clear,
  output logic timeout_evt,
  output logic timeout_flag
);

  logic [CNT_W-1:0] wait_cnt_q;
  logic             waiting;

  assign waiting     = mon_en & bus_idle & owner_req;
  assign timeout_evt = waiting && (wait_cnt_q == CNT_W'(WAIT_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt_q   <= '0;
      timeout_flag <= 1'b0;
    end else begin
      if (!waiting || timeout_evt || grant_moves) wait_cnt_q <= '0;
      else                                         wait_cnt_q <= wait_cnt_q + 1'b1;

      if (timeout_evt)   timeout_flag <= 1'b1;
      else if (to_clear) timeout_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS  = 8,
  parameter int OPT_FIRST  = 5,
  parameter int WAIT_LIMIT = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_MASTERS-1:0]          req_n,
  input  logic                          frame_n,
  input  logic                          irdy_n,
  input  logic [N_MASTERS-1:0]          prio_hi,
  input  logic                          park_fixed,
  input  logic [$clog2(N_MASTERS)-1:0]  park_sel,
  input  logic [N_MASTERS-OPT_FIRST-1:0] opt_en,
  input  logic                          mon_en,
  input  logic                          to_clear,
  output logic [N_MASTERS-1:0]          gnt_n,
  output logic                          timeout_flag
);

  localparam int IDX_W = $clog2(N_MASTERS);

  // Registered state
  logic [IDX_W-1:0] owner_q, last_hi_q, last_lo_q;
  logic             frame_q;

  // Named events for the checker
  logic bus_idle, txn_start, arb_ok, owner_ok, timeout_evt, grant_moves;

  logic [N_MASTERS-1:0] present_vec, owner_hot, eligible, hi_cand, lo_cand;
  logic [IDX_W-1:0]     eff_hi, eff_lo, hi_idx, lo_idx, park_tgt, decision, owner_d;
  logic                 hi_found, lo_found, rotate;
  win_src_e             win_src;

  // Presence map: fixed requesters always there, optional ones gated.
  for (genvar i = 0; i < N_MASTERS; i++) begin : g_pres
    if (i < OPT_FIRST) begin : g_fixed
      assign present_vec[i] = 1'b1;
    end else begin : g_opt
      assign present_vec[i] = opt_en[i-OPT_FIRST];
    end
  end

  assign owner_hot = {{(N_MASTERS-1){1'b0}}, 1'b1} << owner_q;
  assign owner_ok  = present_vec[owner_q];
  assign gnt_n     = ~owner_hot;

  assign bus_idle  = frame_n & irdy_n;
  assign txn_start = ~frame_n & frame_q;
  assign arb_ok    = bus_idle | txn_start;

  // Offender sits out the decision made at its timeout edge.
  assign eligible = ~req_n & present_vec & ~(timeout_evt ? owner_hot : '0);
  assign hi_cand  = eligible & prio_hi;
  assign lo_cand  = eligible & ~prio_hi;

  // Pointer moves at a start or a timeout; the decision at that edge uses it.
  assign rotate = txn_start | timeout_evt;
  assign eff_hi = (rotate &&  prio_hi[owner_q]) ? owner_q : last_hi_q;
  assign eff_lo = (rotate && !prio_hi[owner_q]) ? owner_q : last_lo_q;

  arb_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick_hi (
    .cand(hi_cand), .last(eff_hi), .found(hi_found), .idx(hi_idx)
  );

  arb_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick_lo (
    .cand(lo_cand), .last(eff_lo), .found(lo_found), .idx(lo_idx)
  );

  arb_park_sel #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_park (
    .park_fixed(park_fixed), .park_sel(park_sel), .owner(owner_q),
    .present(present_vec), .target(park_tgt)
  );

  always_comb begin
    if (hi_found)      win_src = WIN_HIGH;
    else if (lo_found) win_src = WIN_LOW;
    else               win_src = WIN_PARK;
    case (win_src)
      WIN_HIGH: decision = hi_idx;
      WIN_LOW:  decision = lo_idx;
      default:  decision = park_tgt;
    endcase
  end

  always_comb begin
    if (arb_ok)        owner_d = decision;
    else if (owner_ok) owner_d = owner_q;
    else               owner_d = '0;
  end

  assign grant_moves = (owner_d != owner_q);

  arb_wait_mon #(.WAIT_LIMIT(WAIT_LIMIT)) u_mon (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .bus_idle(bus_idle),
    .owner_req(~req_n[owner_q]), .grant_moves(grant_moves), .to_clear(to_clear),
    .timeout_evt(timeout_evt), .timeout_flag(timeout_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= '0;
      last_hi_q <= IDX_W'(N_MASTERS - 1);
      last_lo_q <= IDX_W'(N_MASTERS - 1);
      frame_q   <= 1'b1;
    end else begin
      owner_q   <= owner_d;
      last_hi_q <= eff_hi;
      last_lo_q <= eff_lo;
      frame_q   <= frame_n;
    end
  end

endmodule

// File: rtl/pci_park_arbiter_chk.sv
module pci_park_arbiter_chk #(
  parameter int N_MASTERS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_n,
  input logic [N_MASTERS-1:0] prio_hi,
  input logic [N_MASTERS-1:0] present,
  input logic [N_MASTERS-1:0] gnt_n,
  input logic                 mon_en,
  input logic                 to_clear,
  input logic                 arb_ok,
  input logic                 owner_ok,
  input logic                 timeout_evt,
  input logic                 timeout_flag
);

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) == 1);

  assert_move_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != $past(gnt_n)) |-> ($past(arb_ok) || !$past(owner_ok)));

  assert_high_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_ok && !timeout_evt && (|(~req_n & present & prio_hi)))
      |=> (|(~gnt_n & $past(prio_hi))));

  assert_no_absent_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~gnt_n) & ~$past(present)) == '0);

  assert_timeout_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> timeout_flag);

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> !timeout_evt);

  assert_offender_loses_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && (|(~req_n & present & gnt_n))) |=> (gnt_n != $past(gnt_n)));

  assert_flag_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !to_clear) |=> timeout_flag);

  assert_flag_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (to_clear && !timeout_evt) |=> !timeout_flag);

endmodule

bind pci_park_arbiter pci_park_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .prio_hi(prio_hi),
  .present(present_vec), .gnt_n(gnt_n), .mon_en(mon_en), .to_clear(to_clear),
  .arb_ok(arb_ok), .owner_ok(owner_ok), .timeout_evt(timeout_evt),
  .timeout_flag(timeout_flag)
);

// File: tb/pci_park_arbiter_bench.sv
module pci_park_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_n = 8'hFF, prio_hi = 8'h00;
  logic       frame_n = 1'b1, irdy_n = 1'b1;
  logic       park_fixed = 1'b0, mon_en = 1'b0, to_clear = 1'b0;
  logic [2:0] park_sel = 3'd0, opt_en = 3'b111;
  logic [7:0] gnt_n;
  logic       timeout_flag;

  // Values the test wants on the inputs at the next drive point
  logic [7:0] d_req = 8'hFF, d_prio = 8'h00;
  logic       d_frame = 1'b1, d_irdy = 1'b1, d_fixed = 1'b0, d_mon = 1'b0, d_clr = 1'b0;
  logic [2:0] d_sel = 3'd0, d_opt = 3'b111;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_park_arbiter u_pci_park_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .prio_hi(prio_hi), .park_fixed(park_fixed), .park_sel(park_sel), .opt_en(opt_en),
    .mon_en(mon_en), .to_clear(to_clear), .gnt_n(gnt_n), .timeout_flag(timeout_flag)
  );

  // ---------------- reference model ----------------
  int m_cur = 0, m_lhi = 7, m_llo = 7, m_cnt = 0;
  bit m_flag = 0, m_fq = 1, m_evt = 0;

  function automatic int first_after(logic [7:0] m, int last);
    for (int k = 1; k <= 8; k++) if (m[(last + k) % 8]) return (last + k) % 8;
    return -1;
  endfunction

  task automatic advance();
    logic [7:0] pres, elig;
    bit free, start, ok, waiting;
    int lh, ll, hi, lo, t, nxt;
    pres    = {opt_en, 5'b11111};
    free    = frame_n && irdy_n;
    start   = !frame_n && m_fq;
    ok      = free || start;
    waiting = mon_en && free && !req_n[m_cur];
    m_evt   = waiting && (m_cnt == 15);
    elig    = ~req_n & pres;
    if (m_evt) elig[m_cur] = 1'b0;
    lh = m_lhi; ll = m_llo;
    if (start || m_evt) begin
      if (prio_hi[m_cur]) lh = m_cur; else ll = m_cur;
    end
    if (ok) begin
      hi = first_after(elig & prio_hi, lh);
      lo = first_after(elig & ~prio_hi, ll);
      if (hi >= 0)      nxt = hi;
      else if (lo >= 0) nxt = lo;
      else begin
        t   = park_fixed ? int'(park_sel) : m_cur;
        nxt = pres[t] ? t : 0;
      end
    end else begin
      nxt = pres[m_cur] ? m_cur : 0;
    end
    if (!waiting || m_evt || nxt != m_cur) m_cnt = 0; else m_cnt++;
    if (m_evt) m_flag = 1; else if (to_clear) m_flag = 0;
    m_lhi = lh; m_llo = ll; m_fq = frame_n; m_cur = nxt;
  endtask

  // ---------------- checks ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    check($countones(~gnt_n) == 1, "R2", "one grant", gnt_n, 8'h00);
    check(gnt_n == ~(8'd1 << m_cur), tag, "gnt_n", gnt_n, ~(8'd1 << m_cur));
    check(timeout_flag == m_flag, tag, "flag", {7'd0, timeout_flag}, {7'd0, m_flag});
  endtask

  task automatic expect_owner(input int idx, input string tag);
    check(gnt_n == ~(8'd1 << idx), tag, "owner", gnt_n, ~(8'd1 << idx));
  endtask

  task automatic expect_flag(input bit v, input string tag);
    check(timeout_flag == v, tag, "flag", {7'd0, timeout_flag}, {7'd0, v});
  endtask

  task automatic apply();
    req_n = d_req; frame_n = d_frame; irdy_n = d_irdy; prio_hi = d_prio;
    park_fixed = d_fixed; park_sel = d_sel; opt_en = d_opt; mon_en = d_mon;
    to_clear = d_clr;
    advance();
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    check_outputs(tag);
    apply();
  endtask

  task automatic bus(input logic f, input logic i);
    d_frame = f; d_irdy = i;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0C1A);
    repeat (4) @(negedge clk);
    expect_owner(0, "R1");
    expect_flag(0, "R1");
    rst_n = 1'b1;
    apply();
    step("R1");
    expect_owner(0, "R1");

    // R4: high group beats low group
    d_prio = 8'h08; d_req = 8'hF5;
    step("R4"); step("R4");
    expect_owner(3, "R4");

    // R5: rotation inside the low group (requesters 1, 2, 4)
    d_prio = 8'h00; d_req = 8'hE9;
    step("R5"); step("R5");
    expect_owner(1, "R5");
    bus(0, 1); step("R5");
    bus(0, 0); step("R5");
    expect_owner(2, "R5");
    d_req = 8'hBF; step("R3");             // busy: new request must not steal
    d_req = 8'hE9; step("R3");
    expect_owner(2, "R3");
    bus(1, 1); step("R5");
    bus(0, 1); step("R5");
    bus(1, 1); step("R5");
    expect_owner(4, "R5");
    bus(0, 1); step("R5");
    bus(1, 1); step("R5");
    expect_owner(1, "R5");

    // R6: park on current owner
    d_req = 8'hFF; step("R6"); step("R6"); step("R6");
    expect_owner(1, "R6");

    // R7: park on programmed target
    d_fixed = 1'b1; d_sel = 3'd6; step("R7"); step("R7");
    expect_owner(6, "R7");
    d_sel = 3'd0; step("R7"); step("R7");
    expect_owner(0, "R7");

    // R8: optional requesters
    d_opt = 3'b101; d_sel = 3'd6; step("R8"); step("R8");
    expect_owner(0, "R8");
    d_req = 8'hBF; step("R8"); step("R8");
    expect_owner(0, "R8");
    d_req = 8'hFF; d_sel = 3'd7; step("R8"); step("R8");
    expect_owner(7, "R8");
    bus(0, 0); step("R8");
    d_opt = 3'b001; step("R8"); step("R8");
    expect_owner(0, "R8");
    bus(1, 1); d_opt = 3'b111; d_fixed = 1'b0; step("R8");

    // R9 / R11: requesters 2 and 4 wait, monitor on
    d_mon = 1'b1; d_req = 8'hEB;
    step("R9");
    repeat (16) step("R9");
    expect_flag(0, "R9");
    step("R9");
    expect_flag(1, "R9");
    expect_owner(4, "R11");
    bus(0, 1); step("R12");
    bus(0, 0); step("R12"); step("R12");
    expect_flag(1, "R12");
    d_clr = 1'b1; step("R12"); d_clr = 1'b0; step("R12");
    expect_flag(0, "R12");

    // R12: timeout at the same edge as a held clear
    bus(1, 1); d_req = 8'hFB; d_clr = 1'b1;
    for (int n = 0; n < 60 && !m_evt; n++) step("R12");
    step("R12");
    expect_flag(1, "R12");
    step("R12");
    expect_flag(0, "R12");
    d_clr = 1'b0;

    // R10: monitor off, long wait
    d_mon = 1'b0;
    repeat (40) step("R10");
    expect_flag(0, "R10");

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 250 == 0) begin
        d_prio  = 8'($urandom);
        d_fixed = 1'($urandom);
        d_sel   = 3'($urandom);
        d_opt   = 3'($urandom);
        d_mon   = ($urandom % 3) != 0;
      end
      for (int b = 0; b < 8; b++) d_req[b] = ($urandom % 10) >= 4;
      if (d_frame) d_frame = ($urandom % 4) != 0; else d_frame = ($urandom % 3) == 0;
      d_irdy = d_frame ? (($urandom % 8) != 0) : (($urandom % 2) == 0);
      d_clr  = ($urandom % 25) == 0;
      step("R4 R5 R6 R7 R8 R9 R11 R12");
    end
    step("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule